// File: doc/BRIEF.md
# Supervisor Timer Pending Generator

This block produces two level outputs for a processor's interrupt unit: the supervisor timer pending flag and the guest (virtual-supervisor) timer pending flag. It keeps its own copies of the platform time, the supervisor compare value, the guest compare value, the guest time offset, and the two timer-enable bits found in the machine and hypervisor environment-configuration registers. Software writes reach it as one write-data bus plus one write strobe per register.

The flags are not recomputed every cycle. Each flag has its own set of trigger events, and it is re-evaluated only in a cycle in which one of its triggers fires. In every other cycle it holds its value. The guest flag compares the platform time plus the guest offset, wrapped to 64 bits, against the guest compare value. If a register write and a time strobe fall in the same cycle, the evaluation sees the value being written.

The flags are registered. An event in cycle N shows on the outputs after the clock edge that ends cycle N. The interrupt delegation and priority logic that uses these flags sits downstream and is not part of this block. All pins are plain control and data pins. Nothing here has a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_pend_gen`

## Requirements
- R1: After reset both flags are 0, the two compare registers hold all ones, the offset and the held time hold 0, and both enable bits are 0.
- R2: When it is evaluated, the supervisor flag becomes 1 exactly when the machine enable bit (write-data bit 63 of the machine config write) is 1 and time >= supervisor compare, compared as unsigned 64-bit values. Otherwise it becomes 0.
- R3: The supervisor flag is re-evaluated only in a cycle with a time strobe, a supervisor-compare write or a machine-config write. In all other cycles it holds, including across guest-compare, offset and hypervisor-config writes.
- R4: When it is evaluated, the guest flag becomes 1 exactly when both enable bits (bit 63 of each config write) are 1 and (time + offset) mod 2^64 >= guest compare, compared unsigned. Otherwise it becomes 0.
- R5: The guest flag is re-evaluated only in a cycle with a time strobe or a write to the guest compare, the offset, the machine config or the hypervisor config. In all other cycles it holds.
- R6: When a register write and a time strobe occur in the same cycle, the evaluation uses the newly written register value and the new time.
- R7: An event in cycle N changes a flag only after the clock edge that ends cycle N. Before that edge the flag keeps its old value.
- R8: When an evaluation is triggered without a time strobe, it uses the time latched at the last strobe. It ignores the time bus, which may carry any value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_vld | input | 1 | Strobe: a new platform time is on time_val |
| time_val | input | 64 | Platform time value |
| scmp_we | input | 1 | Write strobe, supervisor compare |
| vscmp_we | input | 1 | Write strobe, guest compare |
| toff_we | input | 1 | Write strobe, guest time offset |
| menv_we | input | 1 | Write strobe, machine environment config (enable in bit 63) |
| henv_we | input | 1 | Write strobe, hypervisor environment config (enable in bit 63) |
| wdata | input | 64 | Shared write data for all strobes |
| stip | output | 1 | Supervisor timer pending |
| vstip | output | 1 | Guest timer pending |

## Verification
The two functions that can fall in the same cycle are the time update and a register write. The bench raises the time strobe together with a compare write whose new value gives the opposite result from the old one. The flag must follow the written value. The bench also asserts a register write while the time bus carries a stray value with its strobe low, and checks that the held time decides the result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TW       = 64;
  localparam int unsigned STCE_BIT = 63;
  typedef logic [TW-1:0] tword_t;
endpackage

// File: rtl/tmr_csr_bank.sv
module tmr_csr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned W    = TW,
  parameter int unsigned EBIT = STCE_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         time_vld,
  input  logic [W-1:0] time_val,
  input  logic         scmp_we,
  input  logic         vscmp_we,
  input  logic         toff_we,
  input  logic         menv_we,
  input  logic         henv_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] nxt_time,
  output logic [W-1:0] nxt_scmp,
  output logic [W-1:0] nxt_vscmp,
  output logic [W-1:0] nxt_toff,
  output logic         nxt_men,
  output logic         nxt_hen
);
  logic [W-1:0] time_q, scmp_q, vscmp_q, toff_q;
  logic         men_q, hen_q;

  // forward the value being written so same-cycle evaluation sees it
  always_comb begin
    nxt_time  = time_vld ? time_val    : time_q;
    nxt_scmp  = scmp_we  ? wdata       : scmp_q;
    nxt_vscmp = vscmp_we ? wdata       : vscmp_q;
    nxt_toff  = toff_we  ? wdata       : toff_q;
    nxt_men   = menv_we  ? wdata[EBIT] : men_q;
    nxt_hen   = henv_we  ? wdata[EBIT] : hen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      scmp_q  <= '1;
      vscmp_q <= '1;
      toff_q  <= '0;
      men_q   <= 1'b0;
      hen_q   <= 1'b0;
    end else begin
      time_q  <= nxt_time;
      scmp_q  <= nxt_scmp;
      vscmp_q <= nxt_vscmp;
      toff_q  <= nxt_toff;
      men_q   <= nxt_men;
      hen_q   <= nxt_hen;
    end
  end

  assert_toff_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    toff_we |=> toff_q == $past(wdata));
  assert_time_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !time_vld |=> $stable(time_q));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         en,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (evt) pend <= en && (lhs >= rhs);
  end
endmodule

// File: rtl/tmr_pend_gen.sv
module tmr_pend_gen
  import tmr_pkg::*;
#(
  parameter int unsigned W    = TW,
  parameter int unsigned EBIT = STCE_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         time_vld,
  input  logic [W-1:0] time_val,
  input  logic         scmp_we,
  input  logic         vscmp_we,
  input  logic         toff_we,
  input  logic         menv_we,
  input  logic         henv_we,
  input  logic [W-1:0] wdata,
  output logic         stip,
  output logic         vstip
);
  logic [W-1:0] n_time, n_scmp, n_vscmp, n_toff, v_time;
  logic         n_men, n_hen, s_evt, vs_evt;

  tmr_csr_bank #(.W(W), .EBIT(EBIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .time_vld(time_vld), .time_val(time_val),
    .scmp_we(scmp_we), .vscmp_we(vscmp_we), .toff_we(toff_we),
    .menv_we(menv_we), .henv_we(henv_we), .wdata(wdata),
    .nxt_time(n_time), .nxt_scmp(n_scmp), .nxt_vscmp(n_vscmp),
    .nxt_toff(n_toff), .nxt_men(n_men), .nxt_hen(n_hen)
  );

  // each flag has its own trigger set
  assign s_evt  = time_vld | scmp_we | menv_we;
  assign vs_evt = time_vld | vscmp_we | toff_we | menv_we | henv_we;
  assign v_time = n_time + n_toff;  // wraps modulo 2^W

  tmr_cmp #(.W(W)) u_scmp (
    .clk(clk), .rst_n(rst_n), .evt(s_evt), .en(n_men),
    .lhs(n_time), .rhs(n_scmp), .pend(stip)
  );

  tmr_cmp #(.W(W)) u_vscmp (
    .clk(clk), .rst_n(rst_n), .evt(vs_evt), .en(n_men && n_hen),
    .lhs(v_time), .rhs(n_vscmp), .pend(vstip)
  );

  assert_stip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(time_vld || scmp_we || menv_we) |=> $stable(stip));
  assert_vstip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(time_vld || vscmp_we || toff_we || menv_we || henv_we) |=> $stable(vstip));
  assert_menv_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (menv_we && !wdata[EBIT]) |=> (!stip && !vstip));
  assert_henv_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (henv_we && !wdata[EBIT]) |=> !vstip);
endmodule

// File: tb/tmr_pend_gen_bench.sv
module tmr_pend_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        time_vld = 1'b0;
  logic [63:0] time_val = '0;
  logic        scmp_we = 1'b0, vscmp_we = 1'b0, toff_we = 1'b0;
  logic        menv_we = 1'b0, henv_we = 1'b0;
  logic [63:0] wdata = '0;
  logic        stip, vstip;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  localparam logic [63:0] EN  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE = '1;

  always #5 clk = ~clk;

  tmr_pend_gen u_tmr_pend_gen (
    .clk(clk), .rst_n(rst_n), .time_vld(time_vld), .time_val(time_val),
    .scmp_we(scmp_we), .vscmp_we(vscmp_we), .toff_we(toff_we),
    .menv_we(menv_we), .henv_we(henv_we), .wdata(wdata),
    .stip(stip), .vstip(vstip)
  );

  task automatic chk(input logic es, input logic ev, input string req);
    checks++;
    if (stip !== es || vstip !== ev) begin
      failures++;
      $display("FAIL %s: stip=%b vstip=%b expected stip=%b vstip=%b",
               req, stip, vstip, es, ev);
    end
  endtask

  // we = {henv, menv, toff, vscmp, scmp}
  task automatic step(input logic tv, input logic [63:0] t,
                      input logic [4:0] we, input logic [63:0] d);
    @(negedge clk);
    time_vld = tv; time_val = t; wdata = d;
    {henv_we, menv_we, toff_we, vscmp_we, scmp_we} = we;
    @(negedge clk);
    time_vld = 1'b0;
    {henv_we, menv_we, toff_we, vscmp_we, scmp_we} = '0;
  endtask

  task automatic t_reset;
    chk(0, 0, "R1 reset flags");
    step(0, 64'd0, 5'b01000, EN);
    chk(0, 0, "R1 stimecmp reset all ones");
    step(0, 64'd0, 5'b10000, EN);
    chk(0, 0, "R1 vstimecmp reset all ones");
    step(1, ONE, 5'b00000, 64'd0);
    chk(1, 1, "R2 R4 max time meets reset compare, offset 0 (R1)");
  endtask

  task automatic t_held_time;
    step(1, 64'd500, 5'b00000, 64'd0);
    chk(0, 0, "R2 time below compare");
    step(0, 64'd0, 5'b00001, 64'd400);
    chk(1, 0, "R8 compare write uses held time");
    step(0, 64'd0, 5'b00010, 64'd0);
    chk(1, 1, "R8 R5 guest compare write, stray time bus ignored");
  endtask

  task automatic t_wrap;
    step(0, 64'd0, 5'b00010, 64'd100);
    chk(1, 1, "R5 guest compare 100 vs 500");
    step(0, 64'd0, 5'b00100, 64'hFFFF_FFFF_FFFF_FE3E); // -450
    chk(1, 0, "R4 offset wraps to 50 below 100");
    step(0, 64'd0, 5'b00100, 64'hFFFF_FFFF_FFFF_FE70); // -400
    chk(1, 1, "R4 wrapped sum equals compare");
  endtask

  task automatic t_same_cycle;
    step(1, 64'd1000, 5'b00001, 64'd2000);
    chk(0, 1, "R6 same-cycle compare write wins");
    step(1, 64'd2000, 5'b00000, 64'd0);
    chk(1, 1, "R2 equal boundary");
    step(1, 64'd1999, 5'b00000, 64'd0);
    chk(0, 1, "R2 one below compare");
  endtask

  task automatic t_timing_and_hold;
    step(1, 64'd3000, 5'b00000, 64'd0);
    chk(1, 1, "R2 above compare");
    @(negedge clk);
    henv_we = 1'b1; wdata = 64'd0;
    #1 chk(1, 1, "R7 no change before edge");
    @(negedge clk);
    henv_we = 1'b0;
    chk(1, 0, "R3 R4 hypervisor disable clears guest flag only");
    step(0, 64'd0, 5'b00110, 64'd0);
    chk(1, 0, "R3 R5 guest writes leave stip, guest disabled");
    step(0, 64'd0, 5'b10000, EN);
    chk(1, 1, "R5 hypervisor enable re-evaluates");
    step(0, 64'd0, 5'b01000, 64'd0);
    chk(0, 0, "R2 R4 machine disable clears both");
    step(0, 64'd0, 5'b00001, 64'd0);
    chk(0, 0, "R2 enable off keeps stip low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_held_time();
    t_wrap();
    t_same_cycle();
    t_timing_and_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule